// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block decides whether a processor takes an external interrupt at an instruction boundary. It compares the encoded request level from devices against the mask field of the status word. When it takes a request, it switches to supervisor state and raises the mask to the level it accepted. It then steps through a fixed sequence: a status-word save strobe, a program-counter save strobe, and an acknowledge cycle that shows the serviced level to the device.

The device ends the acknowledge cycle in one of two ways. It can ask for an auto-vector, which uses a fixed table slot per level. It can instead present an 8-bit vector number on the low data byte. The vector number is scaled into a table of four-byte entries that starts at byte address zero. The resulting handler address is shown for one cycle.

A return-from-exception strobe reloads the mask and privilege bit from the saved copy, which software supplies. The highest level cannot be masked. It is taken once for each rising transition to that level.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the unit is idle, with the mask at 7, the privilege bit at 1 (supervisor), and no strobe, acknowledge or vector output active.
- R2: A request of level 1 to 6 is taken at a boundary strobe only if its level is strictly greater than the mask. Level 0 is never taken.
- R3: A level-7 request is taken whatever the mask, even a mask of 7. It is taken once for each rising transition of the request to 7. While the request stays at 7 it is not taken again.
- R4: In the cycle after a request is taken, `priv_o` is 1 and `mask_o` equals the accepted level. `saved_priv_o`/`saved_mask_o` show the status from before the request was taken.
- R5: A taken request produces `push_sr_o` for exactly one cycle, then `push_pc_o` for one cycle, then the acknowledge phase. At most one of these phases, or the vector strobe, is active in any cycle.
- R6: `ack_o` stays high and `ack_lvl_o` stays steady until the device raises `autovec_i` or `vec_valid_i`. In the next cycle `vec_strobe_o` is high for one cycle, and then the unit is idle.
- R7: If `autovec_i` is high when the acknowledge ends, the handler address is 0x60 + 4 × level (level 2 gives 0x68). This holds even when `vec_valid_i` is also high.
- R8: If only `vec_valid_i` ends the acknowledge, the handler address is 4 × `data_i[7:0]`. The upper data bits are ignored, so vector 64 gives 0x100.
- R9: While a sequence is running, boundary strobes, return strobes and rising transitions to level 7 have no effect. The mask and privilege bit do not change.
- R10: When idle, `rte_i` loads the mask from `rte_mask_i` and the privilege bit from `rte_priv_i` in the next cycle. A boundary strobe in the same cycle as `rte_i` takes nothing.
- R11: Without a boundary strobe, no request is taken, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary; requests are sampled only here |
| req_lvl_i | input | 3 | Encoded request level, 0 = none |
| autovec_i | input | 1 | Device ends acknowledge and asks for the auto-vector slot |
| vec_valid_i | input | 1 | Device ends acknowledge with a vector number on the data bus |
| data_i | input | DATA_W | Data bus; low byte carries the vector number |
| rte_i | input | 1 | Return-from-exception restore strobe |
| rte_mask_i | input | 3 | Mask value to restore |
| rte_priv_i | input | 1 | Privilege bit to restore |
| busy_o | output | 1 | Acceptance sequence in progress |
| push_sr_o | output | 1 | Save status word to supervisor stack |
| push_pc_o | output | 1 | Save program counter to supervisor stack |
| saved_mask_o | output | 3 | Mask value to be saved |
| saved_priv_o | output | 1 | Privilege bit to be saved |
| ack_o | output | 1 | Interrupt acknowledge cycle |
| ack_lvl_o | output | 3 | Level being serviced |
| vec_strobe_o | output | 1 | Handler address valid |
| vec_addr_o | output | ADDR_W | Byte address of the handler table entry |
| mask_o | output | 3 | Current mask field |
| priv_o | output | 1 | Current privilege bit, 1 = supervisor |

## Verification
The bench builds the unit with ADDR_W = 10 and DATA_W = 16. Ten bits is the narrowest address that holds vector 255 scaled to 0x3FC, so the top table entry uses the full address width. The 16-bit data bus lets the bench drive a non-zero upper byte and show that it never reaches the address. These settings bring every mask/level pair, both vector paths with both responses at once, and the held and busy-time level-7 cases within a short run.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PUSH_SR,
        SEQ_PUSH_PC,
        SEQ_ACK,
        SEQ_VEC
    } seq_e;

    typedef struct packed {
        logic priv;
        lvl_t mask;
    } sr_t;

endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t req_lvl_i,
    input  lvl_t mask_i,
    input  logic boundary_i,
    input  logic busy_i,
    input  logic block_i,
    output logic take_o,
    output lvl_t take_lvl_o
);

    localparam lvl_t TOP = '1;

    typedef struct packed {
        logic prev;
        logic pend;
    } gate_st_t;

    gate_st_t q, d;
    logic     top_edge;
    logic     window;
    logic     take_top;
    logic     take_norm;

    always_comb begin
        d         = q;
        top_edge  = (req_lvl_i == TOP) && !q.prev;
        window    = boundary_i && !busy_i && !block_i;
        d.prev    = (req_lvl_i == TOP);
        if (top_edge && !busy_i) begin
            d.pend = 1'b1;
        end
        take_top  = window && (q.pend || top_edge);
        take_norm = window && (req_lvl_i != '0) && (req_lvl_i != TOP)
                    && (req_lvl_i > mask_i);
        if (take_top) begin
            d.pend = 1'b0;
        end
        take_o     = take_top || take_norm;
        take_lvl_o = take_top ? TOP : req_lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int AUTO_BASE   = 24
) (
    input  logic              auto_i,
    input  lvl_t              lvl_i,
    input  logic [VEC_W-1:0]  vnum_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int ESH = $clog2(ENTRY_BYTES);

    logic [VEC_W-1:0] num;

    always_comb begin
        num    = auto_i ? (VEC_W'(AUTO_BASE) + VEC_W'(lvl_i)) : vnum_i;
        addr_o = ADDR_W'(num) << ESH;
    end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  lvl_t             take_lvl_i,
    input  logic             autovec_i,
    input  logic             vec_valid_i,
    input  logic [VEC_W-1:0] vnum_i,
    output logic             busy_o,
    output logic             push_sr_o,
    output logic             push_pc_o,
    output logic             ack_o,
    output logic             vec_o,
    output lvl_t             lvl_o,
    output logic             auto_o,
    output logic [VEC_W-1:0] vnum_o
);

    typedef struct packed {
        seq_e             st;
        lvl_t             lvl;
        logic             auto_sel;
        logic [VEC_W-1:0] vnum;
    } seq_st_t;

    seq_st_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            SEQ_IDLE: begin
                if (take_i) begin
                    d.st  = SEQ_PUSH_SR;
                    d.lvl = take_lvl_i;
                end
            end
            SEQ_PUSH_SR: d.st = SEQ_PUSH_PC;
            SEQ_PUSH_PC: d.st = SEQ_ACK;
            SEQ_ACK: begin
                if (autovec_i) begin
                    d.auto_sel = 1'b1;
                    d.st       = SEQ_VEC;
                end else if (vec_valid_i) begin
                    d.auto_sel = 1'b0;
                    d.vnum     = vnum_i;
                    d.st       = SEQ_VEC;
                end
            end
            SEQ_VEC: d.st = SEQ_IDLE;
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= SEQ_IDLE;
            q.lvl      <= '0;
            q.auto_sel <= 1'b0;
            q.vnum     <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != SEQ_IDLE);
    assign push_sr_o = (q.st == SEQ_PUSH_SR);
    assign push_pc_o = (q.st == SEQ_PUSH_PC);
    assign ack_o     = (q.st == SEQ_ACK);
    assign vec_o     = (q.st == SEQ_VEC);
    assign lvl_o     = q.lvl;
    assign auto_o    = q.auto_sel;
    assign vnum_o    = q.vnum;

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 16,
    parameter int VEC_W       = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int AUTO_BASE   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic [LVL_W-1:0]  req_lvl_i,
    input  logic              autovec_i,
    input  logic              vec_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rte_i,
    input  logic [LVL_W-1:0]  rte_mask_i,
    input  logic              rte_priv_i,
    output logic              busy_o,
    output logic              push_sr_o,
    output logic              push_pc_o,
    output logic [LVL_W-1:0]  saved_mask_o,
    output logic              saved_priv_o,
    output logic              ack_o,
    output logic [LVL_W-1:0]  ack_lvl_o,
    output logic              vec_strobe_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic [LVL_W-1:0]  mask_o,
    output logic              priv_o
);

    typedef struct packed {
        sr_t cur;
        sr_t saved;
    } stat_t;

    stat_t            q, d;
    logic             take;
    lvl_t             take_lvl;
    logic             seq_busy;
    logic             seq_auto;
    logic [VEC_W-1:0] seq_vnum;

    generate
        if (DATA_W > VEC_W) begin : g_hi_drop
            logic unused_hi;
            assign unused_hi = ^data_i[DATA_W-1:VEC_W];
        end
    endgenerate

    irq_prio_gate i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_lvl_i  (req_lvl_i),
        .mask_i     (q.cur.mask),
        .boundary_i (boundary_i),
        .busy_i     (seq_busy),
        .block_i    (rte_i),
        .take_o     (take),
        .take_lvl_o (take_lvl)
    );

    irq_seq #(.VEC_W(VEC_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .take_lvl_i  (take_lvl),
        .autovec_i   (autovec_i),
        .vec_valid_i (vec_valid_i),
        .vnum_i      (data_i[VEC_W-1:0]),
        .busy_o      (seq_busy),
        .push_sr_o   (push_sr_o),
        .push_pc_o   (push_pc_o),
        .ack_o       (ack_o),
        .vec_o       (vec_strobe_o),
        .lvl_o       (ack_lvl_o),
        .auto_o      (seq_auto),
        .vnum_o      (seq_vnum)
    );

    irq_vec_calc #(
        .ADDR_W      (ADDR_W),
        .VEC_W       (VEC_W),
        .ENTRY_BYTES (ENTRY_BYTES),
        .AUTO_BASE   (AUTO_BASE)
    ) i_vec (
        .auto_i (seq_auto),
        .lvl_i  (ack_lvl_o),
        .vnum_i (seq_vnum),
        .addr_o (vec_addr_o)
    );

    always_comb begin
        d = q;
        if (rte_i && !seq_busy) begin
            d.cur = {rte_priv_i, rte_mask_i};
        end else if (take) begin
            d.saved = q.cur;
            d.cur   = {1'b1, take_lvl};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cur   <= {1'b1, {LVL_W{1'b1}}};
            q.saved <= {1'b1, {LVL_W{1'b1}}};
        end else begin
            q <= d;
        end
    end

    assign busy_o       = seq_busy;
    assign mask_o       = q.cur.mask;
    assign priv_o       = q.cur.priv;
    assign saved_mask_o = q.saved.mask;
    assign saved_priv_o = q.saved.priv;

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int AUTO_BASE   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              push_sr_o,
    input logic              push_pc_o,
    input logic              ack_o,
    input logic              vec_strobe_o,
    input lvl_t              ack_lvl_o,
    input lvl_t              mask_o,
    input logic              priv_o,
    input lvl_t              saved_mask_o,
    input logic              autovec_i,
    input logic              vec_valid_i,
    input logic [VEC_W-1:0]  data_lo,
    input logic [ADDR_W-1:0] vec_addr_o
);

    // R2: a taken level is non-zero and above the saved mask, or the top level
    p_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_sr_o |-> (ack_lvl_o == 3'd7) ||
                      ((ack_lvl_o != 3'd0) && (ack_lvl_o > saved_mask_o)));

    // R4: supervisor state and raised mask once taken
    p_raise_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_sr_o |-> (priv_o && (mask_o == ack_lvl_o)));

    // R5: save order
    p_sr_then_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_sr_o |=> push_pc_o);

    p_pc_then_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc_o |=> ack_o);

    p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_sr_o, push_pc_o, ack_o, vec_strobe_o}));

    // R6: acknowledge holds until the device answers
    p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !autovec_i && !vec_valid_i) |=> (ack_o && $stable(ack_lvl_o)));

    p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_strobe_o |-> $past(ack_o));

    // R7: auto-vector slot address
    p_auto_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_strobe_o && $past(autovec_i)) |->
            (vec_addr_o == ADDR_W'((AUTO_BASE + int'(ack_lvl_o)) * ENTRY_BYTES)));

    // R8: device vector scaled by entry size
    p_vectored_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_strobe_o && !$past(autovec_i)) |->
            (vec_addr_o == ADDR_W'(int'($past(data_lo)) * ENTRY_BYTES)));

    // R9: status frozen while a sequence runs (except the taking edge)
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !push_sr_o) |-> ($stable(mask_o) && $stable(priv_o)));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(
    .ADDR_W      (ADDR_W),
    .VEC_W       (VEC_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .AUTO_BASE   (AUTO_BASE)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .push_sr_o    (push_sr_o),
    .push_pc_o    (push_pc_o),
    .ack_o        (ack_o),
    .vec_strobe_o (vec_strobe_o),
    .ack_lvl_o    (ack_lvl_o),
    .mask_o       (mask_o),
    .priv_o       (priv_o),
    .saved_mask_o (saved_mask_o),
    .autovec_i    (autovec_i),
    .vec_valid_i  (vec_valid_i),
    .data_lo      (data_i[VEC_W-1:0]),
    .vec_addr_o   (vec_addr_o)
);

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;

    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boundary_i = 1'b0;
    logic [2:0]    req_lvl_i = 3'd0;
    logic          autovec_i = 1'b0;
    logic          vec_valid_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic          rte_i = 1'b0;
    logic [2:0]    rte_mask_i = 3'd0;
    logic          rte_priv_i = 1'b0;
    logic          busy_o, push_sr_o, push_pc_o, saved_priv_o, ack_o, vec_strobe_o, priv_o;
    logic [2:0]    saved_mask_o, ack_lvl_o, mask_o;
    logic [AW-1:0] vec_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_accept_unit #(.ADDR_W(AW), .DATA_W(DW)) i_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_lvl_i(req_lvl_i),
        .autovec_i(autovec_i), .vec_valid_i(vec_valid_i), .data_i(data_i),
        .rte_i(rte_i), .rte_mask_i(rte_mask_i), .rte_priv_i(rte_priv_i),
        .busy_o(busy_o), .push_sr_o(push_sr_o), .push_pc_o(push_pc_o),
        .saved_mask_o(saved_mask_o), .saved_priv_o(saved_priv_o), .ack_o(ack_o),
        .ack_lvl_o(ack_lvl_o), .vec_strobe_o(vec_strobe_o), .vec_addr_o(vec_addr_o),
        .mask_o(mask_o), .priv_o(priv_o)
    );

    typedef struct packed {
        logic [2:0]    mask;
        logic [2:0]    lvl;
        logic          au;
        logic [7:0]    vn;
        logic          take;
        logic [AW-1:0] addr;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{3'd1, 3'd2, 1'b1, 8'd0,   1'b1, 10'h068},
        '{3'd0, 3'd5, 1'b0, 8'd64,  1'b1, 10'h100},
        '{3'd7, 3'd7, 1'b1, 8'd0,   1'b1, 10'h07C},
        '{3'd3, 3'd3, 1'b1, 8'd0,   1'b0, 10'h000},
        '{3'd6, 3'd7, 1'b0, 8'd255, 1'b1, 10'h3FC},
        '{3'd0, 3'd1, 1'b1, 8'd0,   1'b1, 10'h064},
        '{3'd4, 3'd6, 1'b0, 8'd0,   1'b1, 10'h000},
        '{3'd2, 3'd0, 1'b0, 8'd0,   1'b0, 10'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_sr(input logic [2:0] m, input logic p);
        rte_i = 1'b1; rte_mask_i = m; rte_priv_i = p;
        @(negedge clk);
        rte_i = 1'b0;
    endtask

    task automatic strobe_boundary();
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
    endtask

    task automatic drain();
        while (!ack_o) @(negedge clk);
        autovec_i = 1'b1;
        @(negedge clk);
        autovec_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic trial(input logic [2:0] m, input logic [2:0] lv, input logic au,
                         input logic [7:0] vn, input logic et, input logic [AW-1:0] ea);
        req_lvl_i = 3'd0;
        set_sr(m, 1'b0);
        @(negedge clk);
        req_lvl_i = lv;
        @(negedge clk);
        strobe_boundary();
        if (!et) begin
            chk("R2 not taken", 32'(busy_o), 32'd0);
            chk("R2 mask kept", 32'(mask_o), 32'(m));
        end else begin
            chk(lv == 3'd7 ? "R3 taken" : "R2 taken", 32'(push_sr_o), 32'd1);
            chk("R4 mask raised", 32'(mask_o), 32'(lv));
            chk("R4 supervisor", 32'(priv_o), 32'd1);
            chk("R4 saved status", 32'({saved_priv_o, saved_mask_o}), 32'({1'b0, m}));
            @(negedge clk);
            chk("R5 pc push", 32'(push_pc_o), 32'd1);
            @(negedge clk);
            chk("R6 ack", 32'(ack_o), 32'd1);
            chk("R6 ack level", 32'(ack_lvl_o), 32'(lv));
            @(negedge clk);
            chk("R6 ack waits", 32'(ack_o), 32'd1);
            autovec_i = au; vec_valid_i = 1'b1; data_i = {8'hA5, vn};
            @(negedge clk);
            autovec_i = 1'b0; vec_valid_i = 1'b0; data_i = '0;
            chk("R6 vec strobe", 32'(vec_strobe_o), 32'd1);
            chk(au ? "R7 auto addr" : "R8 vector addr", 32'(vec_addr_o), 32'(ea));
            @(negedge clk);
            chk("R6 back idle", 32'(busy_o), 32'd0);
        end
        req_lvl_i = 3'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", 32'(mask_o), 32'd7);
        chk("R1 priv", 32'(priv_o), 32'd1);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 strobes", 32'({push_sr_o, push_pc_o, ack_o, vec_strobe_o}), 32'd0);

        // table walk: R2 R3 R7 R8
        for (int i = 0; i < 8; i++) begin
            trial(ROWS[i].mask, ROWS[i].lvl, ROWS[i].au, ROWS[i].vn,
                  ROWS[i].take, ROWS[i].addr);
        end

        // every mask/level pair: R2 R3
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                trial(3'(m), 3'(l), l[0], 8'(m * 32 + l * 4 + 1),
                      (l == 7) || (l != 0 && l > m),
                      l[0] ? AW'(96 + 4 * l) : AW'((m * 32 + l * 4 + 1) * 4));
            end
        end

        // R3: held level 7 is taken once only
        req_lvl_i = 3'd0;
        set_sr(3'd0, 1'b0);
        @(negedge clk);
        req_lvl_i = 3'd7;
        @(negedge clk);
        strobe_boundary();
        chk("R3 first take", 32'(push_sr_o), 32'd1);
        drain();
        set_sr(3'd0, 1'b0);
        strobe_boundary();
        chk("R3 held no retake", 32'(busy_o), 32'd0);
        req_lvl_i = 3'd0;

        // R9: level-7 edge and return strobe while busy are ignored
        set_sr(3'd0, 1'b0);
        req_lvl_i = 3'd3;
        @(negedge clk);
        strobe_boundary();
        chk("R9 setup take", 32'(push_sr_o), 32'd1);
        req_lvl_i = 3'd7;
        while (!ack_o) @(negedge clk);
        rte_i = 1'b1; rte_mask_i = 3'd0; rte_priv_i = 1'b0;
        @(negedge clk);
        rte_i = 1'b0;
        autovec_i = 1'b1;
        @(negedge clk);
        autovec_i = 1'b0;
        @(negedge clk);
        chk("R9 mask frozen", 32'(mask_o), 32'd3);
        chk("R9 priv frozen", 32'(priv_o), 32'd1);
        strobe_boundary();
        chk("R9 edge during busy dropped", 32'(busy_o), 32'd0);
        req_lvl_i = 3'd0;

        // R10: return strobe wins over boundary, restores status
        set_sr(3'd0, 1'b0);
        req_lvl_i = 3'd4;
        rte_i = 1'b1; rte_mask_i = 3'd6; rte_priv_i = 1'b0; boundary_i = 1'b1;
        @(negedge clk);
        rte_i = 1'b0; boundary_i = 1'b0;
        chk("R10 no take with rte", 32'(busy_o), 32'd0);
        chk("R10 mask restored", 32'(mask_o), 32'd6);
        chk("R10 priv restored", 32'(priv_o), 32'd0);
        strobe_boundary();
        chk("R2 blocked by restored mask", 32'(busy_o), 32'd0);
        set_sr(3'd2, 1'b1);
        chk("R10 second restore", 32'({priv_o, mask_o}), 32'({1'b1, 3'd2}));

        // R11: no boundary, no take
        set_sr(3'd0, 1'b0);
        req_lvl_i = 3'd5;
        repeat (6) @(negedge clk);
        chk("R11 no boundary", 32'(busy_o), 32'd0);
        chk("R11 mask unchanged", 32'(mask_o), 32'd0);
        strobe_boundary();
        chk("R11 boundary takes", 32'(push_sr_o), 32'd1);
        drain();
        req_lvl_i = 3'd0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule